// File: doc/BRIEF.md
# Multi-core interrupt router

This block collects every interrupt source of a four-core cluster and turns them into one IRQ line and one FIQ line per core. Each core brings four timer interrupt lines and four mailbox-pending flags. The cluster shares one GPU IRQ line, one GPU FIQ line, and a local countdown timer that reports an enable flag and a pending flag. The mailbox storage and the countdown timer sit outside the block and reach it only as these level inputs.

For each core, a timer control register and a mailbox control register give every source a two-bit enable, one bit for IRQ and one for FIQ. If both bits are set, the FIQ enable takes precedence. The GPU IRQ and the GPU FIQ can each be steered to any core, and so can the local timer. Every clock edge the block rebuilds a 12-bit IRQ source map and a 12-bit FIQ source map for each core from the current input levels. A core's output line is the OR of its map. Software reaches all registers through a simple 32-bit register port: a single-cycle write strobe and a combinational read.

Top module: `core_irq_router`

## Requirements
- R1: In each source map, bits 3..0 carry timer lines 0..3, bits 7..4 carry mailboxes 0..3, bit 8 carries the GPU, and bit 11 carries the local timer. Bits 9 and 10 always read zero.
- R2: Each timer control register and each mailbox control register stores only write-data bits 7..0. Bit n (0..3) enables source n as an IRQ and bit n+4 enables it as an FIQ. A read returns the stored byte with bits 31..8 zero.
- R3: A source whose FIQ enable is set appears only in the FIQ map, whether or not its IRQ enable is set. A source with neither enable set appears in neither map.
- R4: The GPU route register stores write-data bits 1..0 as the core that receives the GPU IRQ and bits 3..2 as the core that receives the GPU FIQ. A read returns the same packing with the upper bits zero. The GPU IRQ and the GPU FIQ are routed independently.
- R5: The local timer routing register stores write-data bits 2..0. Bits 1..0 select the core and bit 2 selects FIQ (1) or IRQ (0). The local timer reaches its selected map only while both its enable input and its pending input are high.
- R6: irq_o[c] is high exactly when core c's IRQ map is non-zero, and fiq_o[c] is high exactly when its FIQ map is non-zero.
- R7: The register offsets are: 0x0C GPU route, 0x24 local timer routing, 0x40+4c timer control of core c, 0x50+4c mailbox control of core c, 0x60+4c IRQ map of core c, 0x70+4c FIQ map of core c.
- R8: The source maps are registered and follow the input levels with one clock of latency. Writes to the map offsets are ignored.
- R9: Reset clears all control and route registers. After reset the maps are zero and, with the GPU and local timer inputs low, timer and mailbox inputs stay masked and every output is low.
- R10: Reads of unmapped offsets return zero. Writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| tmr_irq_i | input | 16 | Timer lines, core c uses bits 4c+3..4c |
| mbox_pend_i | input | 16 | Mailbox-pending flags, core c uses bits 4c+3..4c |
| gpu_irq_i | input | 1 | Shared GPU IRQ level |
| gpu_fiq_i | input | 1 | Shared GPU FIQ level |
| ltmr_en_i | input | 1 | Local timer interrupt enable |
| ltmr_pend_i | input | 1 | Local timer pending flag |
| irq_o | output | 4 | Per-core IRQ output |
| fiq_o | output | 4 | Per-core FIQ output |

## Verification
The assertions assume that every interrupt input is a level signal synchronous to clk_i, and that a route field can never name a core that does not exist, which holds because the core count is a power of two. They also expect the GPU bit to appear in both maps of a core when both GPU lines point at it, so the FIQ-precedence property excludes that bit. The bench changes inputs and register contents only at falling edges and holds them for at least two clock edges before it reads a map. It sweeps every enable pair on every source of every core, all sixteen GPU routes, all eight local timer routes, and a pseudo-random mix.

// File: rtl/cir_pkg.sv
package cir_pkg;
  localparam int SRC_W    = 12;
  localparam int LINES    = 4;
  localparam int CTL_W    = 2 * LINES;
  localparam int BIT_TMR  = 0;
  localparam int BIT_MBOX = 4;
  localparam int BIT_GPU  = 8;
  localparam int BIT_LT   = 11;

  localparam logic [7:0] OFS_GPU_RT  = 8'h0C;
  localparam logic [7:0] OFS_LT_RT   = 8'h24;
  localparam logic [7:0] OFS_TCTL    = 8'h40;
  localparam logic [7:0] OFS_MCTL    = 8'h50;
  localparam logic [7:0] OFS_IRQ_SRC = 8'h60;
  localparam logic [7:0] OFS_FIQ_SRC = 8'h70;

  typedef logic [SRC_W-1:0] src_t;
  typedef struct packed { logic fiq; logic irq; } steer_t;

  // FIQ enable takes precedence over IRQ enable
  function automatic steer_t steer(input logic lvl, input logic ien, input logic fen);
    steer_t s;
    s.fiq = lvl & fen;
    s.irq = lvl & ien & ~fen;
    return s;
  endfunction
endpackage

// File: rtl/cir_regs.sv
module cir_regs
  import cir_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int CORE_W  = 2,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  output logic [DATA_W-1:0]             rdata_o,
  input  src_t [N_CORES-1:0]            irq_src_i,
  input  src_t [N_CORES-1:0]            fiq_src_i,
  output logic [N_CORES-1:0][CTL_W-1:0] tctl_o,
  output logic [N_CORES-1:0][CTL_W-1:0] mctl_o,
  output logic [CORE_W-1:0]             gpu_irq_sel_o,
  output logic [CORE_W-1:0]             gpu_fiq_sel_o,
  output logic [CORE_W-1:0]             lt_sel_o,
  output logic                          lt_fiq_o
);
  localparam int GRT_W = 2 * CORE_W;
  localparam int LRT_W = CORE_W + 1;

  logic [N_CORES-1:0][CTL_W-1:0] tctl_q, mctl_q;
  logic [GRT_W-1:0]              gpu_rt_q;
  logic [LRT_W-1:0]              lt_rt_q;
  logic                          unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:CTL_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tctl_q   <= '0;
      mctl_q   <= '0;
      gpu_rt_q <= '0;
      lt_rt_q  <= '0;
    end else if (we_i) begin
      if (addr_i == ADDR_W'(OFS_GPU_RT)) gpu_rt_q <= wdata_i[GRT_W-1:0];
      if (addr_i == ADDR_W'(OFS_LT_RT))  lt_rt_q  <= wdata_i[LRT_W-1:0];
      for (int c = 0; c < N_CORES; c++) begin
        if (addr_i == ADDR_W'(int'(OFS_TCTL) + 4 * c)) tctl_q[c] <= wdata_i[CTL_W-1:0];
        if (addr_i == ADDR_W'(int'(OFS_MCTL) + 4 * c)) mctl_q[c] <= wdata_i[CTL_W-1:0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(OFS_GPU_RT)) rdata_o = DATA_W'(gpu_rt_q);
    if (addr_i == ADDR_W'(OFS_LT_RT))  rdata_o = DATA_W'(lt_rt_q);
    for (int c = 0; c < N_CORES; c++) begin
      if (addr_i == ADDR_W'(int'(OFS_TCTL) + 4 * c))    rdata_o = DATA_W'(tctl_q[c]);
      if (addr_i == ADDR_W'(int'(OFS_MCTL) + 4 * c))    rdata_o = DATA_W'(mctl_q[c]);
      if (addr_i == ADDR_W'(int'(OFS_IRQ_SRC) + 4 * c)) rdata_o = DATA_W'(irq_src_i[c]);
      if (addr_i == ADDR_W'(int'(OFS_FIQ_SRC) + 4 * c)) rdata_o = DATA_W'(fiq_src_i[c]);
    end
  end

  assign tctl_o        = tctl_q;
  assign mctl_o        = mctl_q;
  assign gpu_irq_sel_o = gpu_rt_q[CORE_W-1:0];
  assign gpu_fiq_sel_o = gpu_rt_q[GRT_W-1:CORE_W];
  assign lt_sel_o      = lt_rt_q[CORE_W-1:0];
  assign lt_fiq_o      = lt_rt_q[CORE_W];
endmodule

// File: rtl/cir_core_route.sv
module cir_core_route
  import cir_pkg::*;
#(
  parameter int CORE_ID = 0,
  parameter int CORE_W  = 2
) (
  input  logic [CTL_W-1:0]  tctl_i,
  input  logic [CTL_W-1:0]  mctl_i,
  input  logic [LINES-1:0]  tmr_i,
  input  logic [LINES-1:0]  mbox_i,
  input  logic              gpu_irq_i,
  input  logic              gpu_fiq_i,
  input  logic [CORE_W-1:0] gpu_irq_sel_i,
  input  logic [CORE_W-1:0] gpu_fiq_sel_i,
  input  logic              lt_act_i,
  input  logic [CORE_W-1:0] lt_sel_i,
  input  logic              lt_fiq_i,
  output src_t              irq_nxt_o,
  output src_t              fiq_nxt_o
);
  localparam logic [CORE_W-1:0] ME = CORE_W'(CORE_ID);

  steer_t st_t, st_m;
  logic   lt_hit;

  always_comb begin
    irq_nxt_o = '0;
    fiq_nxt_o = '0;
    st_t      = '0;
    st_m      = '0;
    for (int j = 0; j < LINES; j++) begin
      st_t = steer(tmr_i[j], tctl_i[j], tctl_i[j+LINES]);
      st_m = steer(mbox_i[j], mctl_i[j], mctl_i[j+LINES]);
      irq_nxt_o[BIT_TMR+j]  = st_t.irq;
      fiq_nxt_o[BIT_TMR+j]  = st_t.fiq;
      irq_nxt_o[BIT_MBOX+j] = st_m.irq;
      fiq_nxt_o[BIT_MBOX+j] = st_m.fiq;
    end
    irq_nxt_o[BIT_GPU] = gpu_irq_i && (gpu_irq_sel_i == ME);
    fiq_nxt_o[BIT_GPU] = gpu_fiq_i && (gpu_fiq_sel_i == ME);
    lt_hit             = lt_act_i && (lt_sel_i == ME);
    irq_nxt_o[BIT_LT]  = lt_hit && !lt_fiq_i;
    fiq_nxt_o[BIT_LT]  = lt_hit && lt_fiq_i;
  end
endmodule

// File: rtl/core_irq_router.sv
module core_irq_router
  import cir_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     reg_we_i,
  input  logic [ADDR_W-1:0]        reg_addr_i,
  input  logic [DATA_W-1:0]        reg_wdata_i,
  output logic [DATA_W-1:0]        reg_rdata_o,
  input  logic [N_CORES*LINES-1:0] tmr_irq_i,
  input  logic [N_CORES*LINES-1:0] mbox_pend_i,
  input  logic                     gpu_irq_i,
  input  logic                     gpu_fiq_i,
  input  logic                     ltmr_en_i,
  input  logic                     ltmr_pend_i,
  output logic [N_CORES-1:0]       irq_o,
  output logic [N_CORES-1:0]       fiq_o
);
  localparam int CORE_W = (N_CORES > 1) ? $clog2(N_CORES) : 1;

  logic [N_CORES-1:0][CTL_W-1:0] tctl, mctl;
  logic [CORE_W-1:0]             gpu_irq_sel, gpu_fiq_sel, lt_sel;
  logic                          lt_fiq, lt_act;
  src_t [N_CORES-1:0]            irq_nxt, fiq_nxt, irq_src_q, fiq_src_q;

  assign lt_act = ltmr_en_i & ltmr_pend_i;

  cir_regs #(
    .N_CORES(N_CORES), .CORE_W(CORE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .we_i          (reg_we_i),
    .addr_i        (reg_addr_i),
    .wdata_i       (reg_wdata_i),
    .rdata_o       (reg_rdata_o),
    .irq_src_i     (irq_src_q),
    .fiq_src_i     (fiq_src_q),
    .tctl_o        (tctl),
    .mctl_o        (mctl),
    .gpu_irq_sel_o (gpu_irq_sel),
    .gpu_fiq_sel_o (gpu_fiq_sel),
    .lt_sel_o      (lt_sel),
    .lt_fiq_o      (lt_fiq)
  );

  for (genvar c = 0; c < N_CORES; c++) begin : g_core
    cir_core_route #(.CORE_ID(c), .CORE_W(CORE_W)) u_route (
      .tctl_i        (tctl[c]),
      .mctl_i        (mctl[c]),
      .tmr_i         (tmr_irq_i[c*LINES +: LINES]),
      .mbox_i        (mbox_pend_i[c*LINES +: LINES]),
      .gpu_irq_i     (gpu_irq_i),
      .gpu_fiq_i     (gpu_fiq_i),
      .gpu_irq_sel_i (gpu_irq_sel),
      .gpu_fiq_sel_i (gpu_fiq_sel),
      .lt_act_i      (lt_act),
      .lt_sel_i      (lt_sel),
      .lt_fiq_i      (lt_fiq),
      .irq_nxt_o     (irq_nxt[c]),
      .fiq_nxt_o     (fiq_nxt[c])
    );
    assign irq_o[c] = |irq_src_q[c];
    assign fiq_o[c] = |fiq_src_q[c];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_src_q <= '0;
      fiq_src_q <= '0;
    end else begin
      irq_src_q <= irq_nxt;
      fiq_src_q <= fiq_nxt;
    end
  end
endmodule

// File: rtl/cir_checker.sv
module cir_checker
  import cir_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int CORE_W  = 2
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [N_CORES*LINES-1:0] tmr_irq_i,
  input logic [N_CORES*LINES-1:0] mbox_pend_i,
  input logic                     gpu_irq_i,
  input logic                     gpu_fiq_i,
  input logic                     ltmr_en_i,
  input logic                     ltmr_pend_i,
  input logic [N_CORES-1:0]       irq_o,
  input logic [N_CORES-1:0]       fiq_o,
  input src_t [N_CORES-1:0]       irq_src,
  input src_t [N_CORES-1:0]       fiq_src,
  input logic [CORE_W-1:0]        gpu_irq_sel,
  input logic [CORE_W-1:0]        gpu_fiq_sel,
  input logic [CORE_W-1:0]        lt_sel,
  input logic                     lt_fiq
);
  localparam src_t NOT_GPU = ~(src_t'(1) << BIT_GPU);

  logic idle;
  assign idle = (tmr_irq_i == '0) && (mbox_pend_i == '0) && !gpu_irq_i && !gpu_fiq_i
                && !(ltmr_en_i && ltmr_pend_i);

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle |=> (irq_o == '0) && (fiq_o == '0)); // R6

  for (genvar c = 0; c < N_CORES; c++) begin : g_chk
    AST_FIQ_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((irq_src[c] & fiq_src[c]) & NOT_GPU) == '0); // R3

    AST_GPU_IRQ_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gpu_irq_i && gpu_irq_sel == CORE_W'(c)) |=> irq_o[c]); // R4

    AST_GPU_FIQ_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gpu_fiq_i && gpu_fiq_sel == CORE_W'(c)) |=> fiq_o[c]); // R4

    AST_LT_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ltmr_en_i && ltmr_pend_i && lt_sel == CORE_W'(c))
        |=> ($past(lt_fiq) ? fiq_o[c] : irq_o[c])); // R5
  end
endmodule

bind core_irq_router cir_checker #(.N_CORES(N_CORES), .CORE_W(CORE_W)) u_cir_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tmr_irq_i   (tmr_irq_i),
  .mbox_pend_i (mbox_pend_i),
  .gpu_irq_i   (gpu_irq_i),
  .gpu_fiq_i   (gpu_fiq_i),
  .ltmr_en_i   (ltmr_en_i),
  .ltmr_pend_i (ltmr_pend_i),
  .irq_o       (irq_o),
  .fiq_o       (fiq_o),
  .irq_src     (irq_src_q),
  .fiq_src     (fiq_src_q),
  .gpu_irq_sel (gpu_irq_sel),
  .gpu_fiq_sel (gpu_fiq_sel),
  .lt_sel      (lt_sel),
  .lt_fiq      (lt_fiq)
);

// File: tb/core_irq_router_bench.sv
module core_irq_router_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] tmr = '0, mbox = '0;
  logic        gpu_irq = 1'b0, gpu_fiq = 1'b0, lt_en = 1'b0, lt_pend = 1'b0;
  logic [3:0]  irq_o, fiq_o;

  int total = 0, bad = 0;

  logic [7:0]  tctl_m [4];
  logic [7:0]  mctl_m [4];
  logic [3:0]  grt_m = '0;
  logic [2:0]  lrt_m = '0;
  logic [31:0] rs = 32'h1357_9BDF;

  always #10 clk = ~clk;

  core_irq_router u_core_irq_router (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .tmr_irq_i(tmr), .mbox_pend_i(mbox),
    .gpu_irq_i(gpu_irq), .gpu_fiq_i(gpu_fiq), .ltmr_en_i(lt_en), .ltmr_pend_i(lt_pend),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // model of a map, from the requirements
  function automatic logic [11:0] exp_src(int c, bit fq);
    logic [11:0] r;
    r = '0;
    for (int j = 0; j < 4; j++) begin
      if (fq) begin
        r[j]   = tmr[c*4+j]  & tctl_m[c][j+4];
        r[4+j] = mbox[c*4+j] & mctl_m[c][j+4];
      end else begin
        r[j]   = tmr[c*4+j]  & tctl_m[c][j] & ~tctl_m[c][j+4];
        r[4+j] = mbox[c*4+j] & mctl_m[c][j] & ~mctl_m[c][j+4];
      end
    end
    r[8]  = fq ? (gpu_fiq && int'(grt_m[3:2]) == c) : (gpu_irq && int'(grt_m[1:0]) == c);
    r[11] = lt_en && lt_pend && int'(lrt_m[1:0]) == c && (lrt_m[2] == fq);
    return r;
  endfunction

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
    if (a == 8'h0C) grt_m = d[3:0];
    if (a == 8'h24) lrt_m = d[2:0];
    for (int c = 0; c < 4; c++) begin
      if (a == 8'(8'h40 + 4*c)) tctl_m[c] = d[7:0];
      if (a == 8'(8'h50 + 4*c)) mctl_m[c] = d[7:0];
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic check_all(string req);
    logic [31:0] d;
    logic [3:0]  ei, ef;
    for (int c = 0; c < 4; c++) begin
      rd(8'(8'h60 + 4*c), d); chk(req, d, {20'b0, exp_src(c, 1'b0)});
      rd(8'(8'h70 + 4*c), d); chk(req, d, {20'b0, exp_src(c, 1'b1)});
      ei[c] = |exp_src(c, 1'b0);
      ef[c] = |exp_src(c, 1'b1);
    end
    chk("R6 irq", {28'b0, irq_o}, {28'b0, ei});
    chk("R6 fiq", {28'b0, fiq_o}, {28'b0, ef});
  endtask

  task automatic check_ctl(string req);
    logic [31:0] d;
    rd(8'h0C, d); chk(req, d, {28'b0, grt_m});
    rd(8'h24, d); chk(req, d, {29'b0, lrt_m});
    for (int c = 0; c < 4; c++) begin
      rd(8'(8'h40 + 4*c), d); chk(req, d, {24'b0, tctl_m[c]});
      rd(8'(8'h50 + 4*c), d); chk(req, d, {24'b0, mctl_m[c]});
    end
  endtask

  task automatic step();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    for (int c = 0; c < 4; c++) begin tctl_m[c] = '0; mctl_m[c] = '0; end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R9 reset state
    chk("R9 irq_o", {28'b0, irq_o}, 32'h0);
    chk("R9 fiq_o", {28'b0, fiq_o}, 32'h0);
    check_ctl("R9");
    check_all("R9");
    tmr = '1; mbox = '1; settle();
    check_all("R9 masked");
    chk("R9 masked out", {24'b0, irq_o, fiq_o}, 32'h0);

    // R2 / R7 byte width and distinct offsets
    for (int c = 0; c < 4; c++) begin
      wr(8'(8'h40 + 4*c), 32'hFFFF_FF00 | 32'(8'h11 * (c + 1)));
      wr(8'(8'h50 + 4*c), 32'hABCD_EF00 | 32'(8'h83 + 8'h13 * c));
    end
    check_ctl("R2");
    check_ctl("R7");
    for (int c = 0; c < 4; c++) begin
      wr(8'(8'h40 + 4*c), 32'h0);
      wr(8'(8'h50 + 4*c), 32'h0);
    end

    // R1 / R3 sweep: every enable pair on every line of every core
    tmr = '1; mbox = '1;
    for (int c = 0; c < 4; c++)
      for (int k = 0; k < 2; k++)
        for (int j = 0; j < 4; j++)
          for (int en = 0; en < 4; en++) begin
            logic [7:0] v;
            v = 8'((en & 1) << j) | 8'(((en >> 1) & 1) << (j + 4));
            wr(8'((k ? 8'h50 : 8'h40) + 4*c), {24'hFFFFFF, v});
            settle();
            check_all("R3");
            wr(8'((k ? 8'h50 : 8'h40) + 4*c), 32'h0);
          end
    // line low while enabled
    wr(8'h44, 32'h0000_00F0);
    tmr = '0; settle();
    check_all("R3 low");
    wr(8'h44, 32'h0);
    tmr = '0; mbox = '0;

    // R4 GPU routing
    for (int rt = 0; rt < 16; rt++) begin
      wr(8'h0C, 32'hFFFF_FFF0 | 32'(rt));
      rd(8'h0C, d); chk("R4 readback", d, 32'(rt));
      for (int g = 0; g < 4; g++) begin
        gpu_irq = g[0]; gpu_fiq = g[1];
        settle();
        check_all("R4");
      end
    end
    gpu_irq = 1'b0; gpu_fiq = 1'b0;

    // R5 local timer routing
    for (int rt = 0; rt < 8; rt++) begin
      wr(8'h24, 32'hFFFF_FFF8 | 32'(rt));
      rd(8'h24, d); chk("R5 readback", d, 32'(rt));
      for (int f = 0; f < 4; f++) begin
        lt_en = f[0]; lt_pend = f[1];
        settle();
        check_all("R5");
      end
    end
    lt_en = 1'b0; lt_pend = 1'b0;
    settle();

    // R8 one-cycle latency and read-only maps
    wr(8'h48, 32'h0000_0001);
    settle();
    @(negedge clk); tmr[8] = 1'b1;
    #1 chk("R8 before edge", {31'b0, irq_o[2]}, 32'h0);
    @(negedge clk);
    #1 chk("R8 after edge", {31'b0, irq_o[2]}, 32'h1);
    @(negedge clk); tmr[8] = 1'b0;
    #1 chk("R8 hold", {31'b0, irq_o[2]}, 32'h1);
    @(negedge clk);
    #1 chk("R8 fall", {31'b0, irq_o[2]}, 32'h0);
    tmr[8] = 1'b1;
    wr(8'h68, 32'h0);
    wr(8'h78, 32'hFFFF_FFFF);
    wr(8'h60, 32'hFFFF_FFFF);
    settle();
    check_all("R8 write ignored");
    check_ctl("R8 write ignored");

    // R10 unmapped offsets
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h38, 32'hFFFF_FFFF);
    wr(8'h80, 32'hFFFF_FFFF);
    wr(8'hFC, 32'hFFFF_FFFF);
    rd(8'h00, d); chk("R10 read 00", d, 32'h0);
    rd(8'h10, d); chk("R10 read 10", d, 32'h0);
    rd(8'h80, d); chk("R10 read 80", d, 32'h0);
    rd(8'hC4, d); chk("R10 read C4", d, 32'h0);
    check_ctl("R10");
    settle();
    check_all("R10");

    // R6 mixed random patterns
    for (int it = 0; it < 200; it++) begin
      int k;
      step(); k = int'(rs % 10);
      step();
      if (k == 0)      wr(8'h0C, rs);
      else if (k == 1) wr(8'h24, rs);
      else if (k < 6)  wr(8'(8'h40 + 4*(k - 2)), rs);
      else             wr(8'(8'h50 + 4*(k - 6)), rs);
      step(); tmr = rs[15:0]; mbox = rs[31:16];
      step(); gpu_irq = rs[0]; gpu_fiq = rs[1]; lt_en = rs[2]; lt_pend = rs[3];
      settle();
      check_all("R6");
    end
    finish_run();
  end
endmodule